// File: doc/BRIEF.md
# TSO Store Buffer with Fences and Line Flushes

This block sits between an in-order issue stream and a single-port write-back cache. It queues stores and line flushes in an age-ordered buffer and drains them to the cache one per cycle. The memory model it keeps is total store order. Loads go straight to the cache, or take their data from the buffer, in the cycle they issue. The buffer relaxes ordering only where the model allows it: non-temporal stores and optimized flushes may drain ahead of unrelated older entries. Strict flushes and store fences act as drain barriers.

The issue side is a valid/ready pair carrying an operation code, a word address, write data and byte enables. The cache side is a valid/ready pair with a command, address, data and byte enables. Read data returns in the same cycle the cache accepts the read. Load results come out one cycle after the load is accepted.

Top module: `tso_store_buffer`

## Requirements
- R1: Loads (op 0) are accepted one at a time in issue order. Each accepted load raises `ld_rsp_valid` for exactly the following cycle, with its data. `ld_rsp_valid` is never high at any other time.
- R2: Ordinary stores (op 1) and strict flushes (op 3) reach the cache in program order. Each waits until every older buffered entry has left. Writes use `mem_cmd` 1 and flushes use `mem_cmd` 2.
- R3: When a buffered store (op 1 or 2) matches a load's word address (address bits 31:2) and the youngest such store writes all four bytes, the load returns that store's data and issues no cache read.
- R4: A load that misses the buffer uses the cache port (`mem_cmd` 0) ahead of any pending drain.
- R5: When the youngest matching buffered store writes only some bytes, the load stalls (`iss_ready` low). It issues only after that store has drained, and then returns the merged memory word.
- R6: Non-temporal stores (op 2) and optimized flushes (op 4) drain ahead of older ordinary stores on other lines (line = address bits 31:6). They never drain ahead of an older entry on their own line.
- R7: A buffered strict flush or store fence (op 6) blocks every younger entry from draining before it. A store fence makes no cache access.
- R8: A store fence does not hold back younger loads. A full fence (op 7) is accepted only when the buffer is empty.
- R9: A load fence (op 5) is accepted in the cycle it is presented, even with the buffer full.
- R10: Stores, flushes and store fences stall at issue while the buffer holds DEPTH entries. The buffer never holds more than DEPTH entries.
- R11: After reset the buffer is empty, `mem_valid` and `ld_rsp_valid` are low, and a store is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Issue request accepted this cycle |
| iss_op | input | 3 | Operation code (0 load, 1 store, 2 non-temporal store, 3 strict flush, 4 optimized flush, 5 load fence, 6 store fence, 7 full fence) |
| iss_addr | input | AW | Byte address |
| iss_wdata | input | DW | Store data |
| iss_be | input | DW/8 | Store byte enables |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_rsp_data | output | DW | Load result data |
| mem_valid | output | 1 | Cache request valid |
| mem_ready | input | 1 | Cache accepts request |
| mem_cmd | output | 2 | 0 read, 1 write, 2 line flush |
| mem_addr | output | AW | Cache request address |
| mem_wdata | output | DW | Cache write data |
| mem_be | output | DW/8 | Cache write byte enables |
| mem_rdata | input | DW | Read data, valid in the read's accept cycle |

## Verification
The bench fills the buffer with mixes of ordinary, non-temporal, flush and fence entries while the cache is held off. It then releases the cache and compares the logged drain order against the order the rules allow. A buffer that drained strictly from the head would fail the relaxed-order checks. A buffer that let relaxed entries jump a same-line store, a strict flush or a store fence would fail the barrier checks. A swept sequence of partial and full byte-enable stores, interleaved with loads, compares every returned word with an arithmetic memory image. Forwarding from the oldest match instead of the youngest, or forwarding a partial write, shows up there as wrong data. Stall windows are sampled for a fixed number of cycles to catch a fence or full buffer that lets an operation through too early.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
   typedef enum logic [2:0] {
      OP_LD   = 3'd0,
      OP_ST   = 3'd1,
      OP_NTST = 3'd2,
      OP_FLS  = 3'd3,
      OP_OFLS = 3'd4,
      OP_LFN  = 3'd5,
      OP_SFN  = 3'd6,
      OP_MFN  = 3'd7
   } op_e;

   localparam logic [1:0] MC_RD = 2'd0;
   localparam logic [1:0] MC_WR = 2'd1;
   localparam logic [1:0] MC_FL = 2'd2;
endpackage

// File: rtl/tso_sb_fwd.sv
module tso_sb_fwd
   import tso_sb_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input  logic [DEPTH-1:0]               vld,
   input  logic [DEPTH-1:0][2:0]          op,
   input  logic [DEPTH-1:0][AW-1:0]       addr,
   input  logic [DEPTH-1:0][DW-1:0]       data,
   input  logic [DEPTH-1:0][DW/8-1:0]     be,
   input  logic [AW-1:0]                  ld_addr,
   output logic                           hit,
   output logic                           full,
   output logic [DW-1:0]                  fdata
);
   localparam int WOFF = $clog2(DW/8);

   // youngest matching store wins: higher index is younger
   always_comb begin
      hit   = 1'b0;
      full  = 1'b0;
      fdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld[i] && (op[i] == OP_ST || op[i] == OP_NTST) &&
             addr[i][AW-1:WOFF] == ld_addr[AW-1:WOFF]) begin
            hit   = 1'b1;
            full  = &be[i];
            fdata = data[i];
         end
      end
   end
endmodule

// File: rtl/tso_sb_pick.sv
module tso_sb_pick
   import tso_sb_pkg::*;
#(
   parameter int DEPTH         = 8,
   parameter int AW            = 32,
   parameter int LINE_BYTES    = 64,
   parameter bit RELAXED_FIRST = 1'b1
) (
   input  logic [DEPTH-1:0]               vld,
   input  logic [DEPTH-1:0][2:0]          op,
   input  logic [DEPTH-1:0][AW-1:0]       addr,
   output logic                           sel_vld,
   output logic [$clog2(DEPTH)-1:0]       sel_idx
);
   localparam int IW   = $clog2(DEPTH);
   localparam int LOFF = $clog2(LINE_BYTES);

   generate
      if (RELAXED_FIRST) begin : g_relaxed
         logic          found;
         logic [IW-1:0] idx;
         logic          ok;
         // oldest relaxed entry with no older barrier and no older same-line entry
         always_comb begin
            found = 1'b0;
            idx   = '0;
            ok    = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
               ok = vld[i] && (op[i] == OP_NTST || op[i] == OP_OFLS);
               for (int j = 0; j < DEPTH; j++) begin
                  if (j < i && (op[j] == OP_SFN || op[j] == OP_FLS ||
                                addr[j][AW-1:LOFF] == addr[i][AW-1:LOFF]))
                     ok = 1'b0;
               end
               if (ok && !found) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
         assign sel_vld = found | vld[0];
         assign sel_idx = found ? idx : '0;
      end else begin : g_inorder
         assign sel_vld = vld[0];
         assign sel_idx = '0;
      end
   endgenerate
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
   import tso_sb_pkg::*;
#(
   parameter int DEPTH         = 8,
   parameter int AW            = 32,
   parameter int DW            = 32,
   parameter int LINE_BYTES    = 64,
   parameter bit RELAXED_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic [2:0]        iss_op,
   input  logic [AW-1:0]     iss_addr,
   input  logic [DW-1:0]     iss_wdata,
   input  logic [DW/8-1:0]   iss_be,
   output logic              ld_rsp_valid,
   output logic [DW-1:0]     ld_rsp_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [1:0]        mem_cmd,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW/8-1:0]   mem_be,
   input  logic [DW-1:0]     mem_rdata
);
   localparam int BEW = DW / 8;
   localparam int IW  = $clog2(DEPTH);
   localparam int CW  = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tso_store_buffer: DEPTH must be at least 2");
      end
      if (DW % 8 != 0 || DW < 16) begin : g_bad_dw
         $error("tso_store_buffer: DW must be a multiple of 8, at least 16");
      end
      if (LINE_BYTES < BEW || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("tso_store_buffer: LINE_BYTES must be a power of two not below DW/8");
      end
   endgenerate

   logic [DEPTH-1:0][2:0]      e_op;
   logic [DEPTH-1:0][AW-1:0]   e_addr;
   logic [DEPTH-1:0][DW-1:0]   e_data;
   logic [DEPTH-1:0][BEW-1:0]  e_be;
   logic [CW-1:0]              count;
   logic [DEPTH-1:0]           vld;

   for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign vld[g] = (CW'(g) < count);
   end

   logic          fwd_hit, fwd_full;
   logic [DW-1:0] fwd_data;
   logic          pk_vld;
   logic [IW-1:0] pk_idx;
   logic [2:0]    pk_op;
   logic          pk_mark;

   tso_sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
      .vld(vld), .op(e_op), .addr(e_addr), .data(e_data), .be(e_be),
      .ld_addr(iss_addr), .hit(fwd_hit), .full(fwd_full), .fdata(fwd_data)
   );

   tso_sb_pick #(.DEPTH(DEPTH), .AW(AW), .LINE_BYTES(LINE_BYTES),
                 .RELAXED_FIRST(RELAXED_FIRST)) u_pick (
      .vld(vld), .op(e_op), .addr(e_addr), .sel_vld(pk_vld), .sel_idx(pk_idx)
   );

   assign pk_op   = e_op[pk_idx];
   assign pk_mark = (pk_op == OP_SFN);

   logic is_ld, is_buf, ld_mem, pop, push, iss_fire;
   assign is_ld  = (iss_op == OP_LD);
   assign is_buf = (iss_op == OP_ST) || (iss_op == OP_NTST) || (iss_op == OP_FLS) ||
                   (iss_op == OP_OFLS) || (iss_op == OP_SFN);
   assign ld_mem = iss_valid && is_ld && !fwd_hit;

   always_comb begin
      unique case (op_e'(iss_op))
         OP_LD:   iss_ready = fwd_hit ? fwd_full : mem_ready;
         OP_LFN:  iss_ready = 1'b1;
         OP_MFN:  iss_ready = (count == '0);
         default: iss_ready = (count < CW'(DEPTH));
      endcase
   end

   assign iss_fire = iss_valid && iss_ready;
   assign push     = iss_fire && is_buf;
   assign pop      = !ld_mem && pk_vld && (pk_mark || mem_ready);

   always_comb begin
      mem_valid = ld_mem || (pk_vld && !pk_mark);
      mem_cmd   = MC_RD;
      mem_addr  = iss_addr;
      mem_wdata = '0;
      mem_be    = '1;
      if (!ld_mem) begin
         mem_cmd   = (pk_op == OP_FLS || pk_op == OP_OFLS) ? MC_FL : MC_WR;
         mem_addr  = e_addr[pk_idx];
         mem_wdata = e_data[pk_idx];
         mem_be    = e_be[pk_idx];
      end
   end

   logic [CW-1:0] wp_full;
   logic [IW-1:0] wp;
   assign wp_full = count - CW'(pop);
   assign wp      = wp_full[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count        <= '0;
         ld_rsp_valid <= 1'b0;
         ld_rsp_data  <= '0;
      end else begin
         count        <= count + CW'(push) - CW'(pop);
         ld_rsp_valid <= iss_fire && is_ld;
         if (iss_fire && is_ld)
            ld_rsp_data <= fwd_hit ? fwd_data : mem_rdata;
      end
   end

   // age-ordered queue: removal at any slot shifts younger entries down
   always_ff @(posedge clk) begin
      if (pop) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(pk_idx)) begin
               e_op[i]   <= e_op[i+1];
               e_addr[i] <= e_addr[i+1];
               e_data[i] <= e_data[i+1];
               e_be[i]   <= e_be[i+1];
            end
         end
      end
      if (push) begin
         e_op[wp]   <= iss_op;
         e_addr[wp] <= iss_addr;
         e_data[wp] <= iss_wdata;
         e_be[wp]   <= iss_be;
      end
   end
endmodule

// File: rtl/tso_sb_chk.sv
module tso_sb_chk
   import tso_sb_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       iss_valid,
   input logic                       iss_ready,
   input logic [2:0]                 iss_op,
   input logic                       ld_rsp_valid,
   input logic                       mem_valid,
   input logic                       mem_ready,
   input logic [1:0]                 mem_cmd,
   input logic [$clog2(DEPTH+1)-1:0] count,
   input logic                       pop,
   input logic [$clog2(DEPTH)-1:0]   pk_idx,
   input logic [2:0]                 pk_op
);
   localparam int CW = $clog2(DEPTH + 1);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && count == CW'(DEPTH) &&
       (iss_op == OP_ST || iss_op == OP_NTST || iss_op == OP_FLS ||
        iss_op == OP_OFLS || iss_op == OP_SFN)) |-> !iss_ready);

   assert_fullfence_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && iss_op == OP_MFN) |-> count == '0);

   assert_ld_rsp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && iss_op == OP_LD) |=> ld_rsp_valid);

   assert_ld_rsp_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rsp_valid |-> $past(iss_valid && iss_ready && iss_op == OP_LD));

   assert_strict_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && mem_cmd != MC_RD &&
       (pk_op == OP_ST || pk_op == OP_FLS)) |-> pk_idx == '0);

   assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);

   assert_lfence_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_op == OP_LFN) |-> iss_ready);
endmodule

bind tso_store_buffer tso_sb_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
   .iss_op(iss_op), .ld_rsp_valid(ld_rsp_valid), .mem_valid(mem_valid),
   .mem_ready(mem_ready), .mem_cmd(mem_cmd), .count(count), .pop(pop),
   .pk_idx(pk_idx), .pk_op(pk_op)
);

// File: tb/tb_tso_store_buffer.sv
`timescale 1ns/1ps
module tb_tso_store_buffer;
   import tso_sb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic        iss_ready;
   logic [2:0]  iss_op = 3'd0;
   logic [31:0] iss_addr = '0;
   logic [31:0] iss_wdata = '0;
   logic [3:0]  iss_be = '0;
   logic        ld_rsp_valid;
   logic [31:0] ld_rsp_data;
   logic        mem_valid;
   logic        mem_ready;
   logic [1:0]  mem_cmd;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;

   logic mr_force = 1'b1, mr_auto = 1'b0, mr_tog = 1'b0;
   assign mem_ready = mr_auto ? mr_tog : mr_force;

   always #2 clk = ~clk;
   always @(negedge clk) mr_tog <= ~mr_tog;

   tso_store_buffer dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_op(iss_op), .iss_addr(iss_addr), .iss_wdata(iss_wdata), .iss_be(iss_be),
      .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_cmd(mem_cmd),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rdata(mem_rdata)
   );

   logic [31:0] tbmem [0:255];
   logic [31:0] exp_mem [0:255];
   logic [1:0]  lg_cmd [0:4095];
   logic [31:0] lg_addr [0:4095];
   int          lg_n = 0;
   int          total = 0, bad = 0, base = 0;

   initial begin
      for (int i = 0; i < 256; i++) begin
         tbmem[i]   = 32'h1000_0000 + i * 32'h0101;
         exp_mem[i] = 32'h1000_0000 + i * 32'h0101;
      end
   end

   assign mem_rdata = tbmem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         lg_cmd[lg_n & 4095]  <= mem_cmd;
         lg_addr[lg_n & 4095] <= mem_addr;
         lg_n <= lg_n + 1;
         if (mem_cmd == MC_WR)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) tbmem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drv(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be);
      @(negedge clk);
      iss_valid = 1'b1; iss_op = op; iss_addr = a; iss_wdata = d; iss_be = be;
      #1;
   endtask

   task automatic fin();
      while (!iss_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      iss_valid = 1'b0;
      if (iss_op == OP_ST || iss_op == OP_NTST)
         for (int b = 0; b < 4; b++)
            if (iss_be[b]) exp_mem[iss_addr[9:2]][8*b +: 8] = iss_wdata[8*b +: 8];
   endtask

   task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be);
      drv(op, a, d, be);
      fin();
   endtask

   task automatic load(input logic [31:0] a, input string req);
      drv(OP_LD, a, 32'h0, 4'hF);
      fin();
      chk({req, " rsp valid"}, {31'b0, ld_rsp_valid}, 32'h1);
      chk({req, " rsp data"}, ld_rsp_data, exp_mem[a[9:2]]);
   endtask

   task automatic drain();
      mr_force = 1'b1;
      issue(OP_MFN, 32'h0, 32'h0, 4'h0);
   endtask

   task automatic stall(input string req, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #1;
         chk(req, {31'b0, iss_ready}, 32'h0);
      end
   endtask

   task automatic lg(input string req, input int k, input logic [1:0] c, input logic [31:0] a);
      chk({req, " cmd"}, {30'b0, lg_cmd[k & 4095]}, {30'b0, c});
      chk({req, " addr"}, lg_addr[k & 4095], a);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; iss_op = OP_ST; #1;
      // R11 reset state
      chk("R11 mem_valid", {31'b0, mem_valid}, 32'h0);
      chk("R11 ld_rsp_valid", {31'b0, ld_rsp_valid}, 32'h0);
      chk("R11 store ready", {31'b0, iss_ready}, 32'h1);

      // R2 program order for stores and strict flush
      mr_force = 1'b0; base = lg_n;
      issue(OP_ST, 32'h000, 32'hA0, 4'hF);
      issue(OP_ST, 32'h040, 32'hA1, 4'hF);
      issue(OP_ST, 32'h080, 32'hA2, 4'hF);
      issue(OP_FLS, 32'h0C0, 32'h0, 4'h0);
      issue(OP_ST, 32'h100, 32'hA4, 4'hF);
      drain();
      lg("R2 e0", base + 0, MC_WR, 32'h000);
      lg("R2 e1", base + 1, MC_WR, 32'h040);
      lg("R2 e2", base + 2, MC_WR, 32'h080);
      lg("R2 e3", base + 3, MC_FL, 32'h0C0);
      lg("R2 e4", base + 4, MC_WR, 32'h100);

      // R3 forward youngest full store, no cache read
      mr_force = 1'b0;
      issue(OP_ST, 32'h200, 32'h1111_1111, 4'hF);
      issue(OP_ST, 32'h200, 32'h2222_2222, 4'hF);
      issue(OP_ST, 32'h204, 32'h0000_3333, 4'h3);
      issue(OP_ST, 32'h204, 32'h4444_4444, 4'hF);
      base = lg_n;
      load(32'h200, "R3 youngest");
      load(32'h204, "R3 full over partial");
      chk("R3 no cache read", lg_n - base, 0);
      drain();

      // R4 miss load takes the port ahead of drain
      mr_force = 1'b0;
      issue(OP_ST, 32'h240, 32'h55, 4'hF);
      issue(OP_ST, 32'h280, 32'h66, 4'hF);
      base = lg_n; mr_force = 1'b1;
      load(32'h300, "R4 load value");
      lg("R4 first op is read", base, MC_RD, 32'h300);
      drain();

      // R5 partial overlap stalls until drained
      mr_force = 1'b0;
      issue(OP_ST, 32'h340, 32'h0000_ABCD, 4'h3);
      drv(OP_LD, 32'h340, 32'h0, 4'hF);
      stall("R5 partial stall", 4);
      mr_force = 1'b1;
      fin();
      chk("R5 rsp valid", {31'b0, ld_rsp_valid}, 32'h1);
      chk("R5 merged data", ld_rsp_data, exp_mem[8'hD0]);
      drain();

      // R6 relaxed entries pass other lines, not own line
      mr_force = 1'b0; base = lg_n;
      issue(OP_ST, 32'h040, 32'h51, 4'hF);
      issue(OP_NTST, 32'h080, 32'h52, 4'hF);
      issue(OP_OFLS, 32'h0C0, 32'h0, 4'h0);
      issue(OP_ST, 32'h044, 32'h54, 4'hF);
      issue(OP_NTST, 32'h048, 32'h55, 4'hF);
      drain();
      lg("R6 nt first", base + 0, MC_WR, 32'h080);
      lg("R6 oflush second", base + 1, MC_FL, 32'h0C0);
      lg("R6 head store", base + 2, MC_WR, 32'h040);
      lg("R6 same line store", base + 3, MC_WR, 32'h044);
      lg("R6 same line nt last", base + 4, MC_WR, 32'h048);

      // R7 strict flush and store fence are barriers
      mr_force = 1'b0; base = lg_n;
      issue(OP_ST, 32'h040, 32'h61, 4'hF);
      issue(OP_FLS, 32'h080, 32'h0, 4'h0);
      issue(OP_NTST, 32'h0C0, 32'h63, 4'hF);
      issue(OP_SFN, 32'h0, 32'h0, 4'h0);
      issue(OP_NTST, 32'h100, 32'h65, 4'hF);
      drain();
      chk("R7 no access for fence", lg_n - base, 4);
      lg("R7 e0", base + 0, MC_WR, 32'h040);
      lg("R7 e1", base + 1, MC_FL, 32'h080);
      lg("R7 e2", base + 2, MC_WR, 32'h0C0);
      lg("R7 e3", base + 3, MC_WR, 32'h100);

      // R8 store fence lets loads pass; full fence waits for empty
      mr_force = 1'b0; base = lg_n;
      issue(OP_ST, 32'h140, 32'h7777_7777, 4'hF);
      issue(OP_SFN, 32'h0, 32'h0, 4'h0);
      load(32'h140, "R8 load past store fence");
      drv(OP_MFN, 32'h0, 32'h0, 4'h0);
      stall("R8 full fence stall", 4);
      mr_force = 1'b1;
      fin();
      chk("R8 buffer drained", lg_n - base, 1);

      // R9 load fence with full buffer; R10 full stall
      mr_force = 1'b0;
      for (int k = 0; k < 8; k++) issue(OP_ST, 32'h380 + 4 * k, 32'h900 + k, 4'hF);
      drv(OP_LFN, 32'h0, 32'h0, 4'h0);
      chk("R9 load fence ready", {31'b0, iss_ready}, 32'h1);
      fin();
      drv(OP_ST, 32'h3E0, 32'h9FF, 4'hF);
      stall("R10 full stall", 4);
      mr_force = 1'b1;
      fin();
      drain();
      for (int k = 0; k < 8; k++) load(32'h380 + 4 * k, "R10 data");
      load(32'h3E0, "R10 late store");

      // sweep: mixed stores, byte enables, flushes and loads, R3 R5 R6
      mr_auto = 1'b1;
      for (int k = 0; k < 96; k++) begin
         logic [31:0] a;
         a = 32'(((k * 5) % 32) * 4);
         issue((k % 4 == 3) ? OP_NTST : OP_ST, a, 32'(k) * 32'h0101_0101 ^ 32'hA5A5_5AA5,
               4'((k % 15) + 1));
         if (k % 8 == 5) issue(OP_OFLS, a, 32'h0, 4'h0);
         if (k % 3 == 2) load(32'(((k * 3) % 32) * 4), "R5 sweep load");
      end
      issue(OP_MFN, 32'h0, 32'h0, 4'h0);
      for (int w = 0; w < 32; w++) load(32'(w * 4), "R6 sweep final");
      mr_auto = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule